// File: doc/BRIEF.md
# Serial Driver Loader

This block loads one or more cascaded 32-channel serial-in, parallel-out driver chips from inside a synchronous design. A host hands over a whole frame of N_DEV × 32 bits in one transfer through a valid/ready handshake. The block then produces a divided shift clock and a serial data line. When every bit has been clocked out, it sends a single latch pulse that copies the chain's shift stages into the output latches. A separate output-enable line follows a host request one cycle later and can blank the driver outputs at any moment.

Every edge on the driver pins is placed by a down-counter that runs in system-clock cycles. The driver's minimum times are turned into cycle counts at elaboration, from the system clock frequency, by rounding up. The serial data only moves while the shift clock is low, which gives setup and hold margins of whole low and high phases. The latch pulse is kept a minimum distance from the rising shift-clock edges on both sides.

Top module: `serdrv_loader`

## Requirements
- R1: `frame_ready` is high only while the block is idle. A frame is taken on a clock edge where `frame_valid` and `frame_ready` are both high, and `frame_ready` is low in the cycle after that edge. While `frame_ready` is high, `drv_sclk` and `drv_le` are low.
- R2: Changes on `frame_data` and `frame_valid` after a frame has been taken, and before `frame_ready` returns, have no effect on the bits that end up latched.
- R3: A frame produces exactly FRAME_W rising edges on `drv_sclk`. Bit FRAME_W-1 of `frame_data` is sent first and bit 0 last. In a chain that moves one stage per rising edge, shifting in at position 0, position i then holds frame bit i, so position FRAME_W-1 is the far stage of the last device.
- R4: Each high phase of `drv_sclk` lasts exactly HI = ceil(62 ns × CLK_HZ) cycles. Each low phase lasts at least LO = max(HI, ceil(125 ns × CLK_HZ) − HI) cycles. Together these keep the shift clock at or below 8 MHz.
- R5: `drv_sdat` changes only while `drv_sclk` is low. It is stable for at least ceil(25 ns) cycles before each rising edge and for at least ceil(10 ns) cycles after it.
- R6: Each frame gives exactly one `drv_le` pulse. The pulse rises at least LE = ceil(50 ns × CLK_HZ) cycles after the frame's last rising edge, lasts at least LE cycles, and `drv_sclk` stays low while `drv_le` is high.
- R7: After `drv_le` falls, at least LE cycles pass before the next rising edge of `drv_sclk`, including when the frames run back to back.
- R8: `drv_oe` equals the value `oe_req` had one cycle earlier, whatever the state of frame loading.
- R9: While `rst` is high and in the first cycle after it, `drv_sclk`, `drv_sdat`, `drv_le` and `drv_oe` are low and `frame_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_valid | input | 1 | Host offers a frame |
| frame_ready | output | 1 | Block is idle and will take a frame |
| frame_data | input | N_DEV*DEV_BITS | Frame bits; the top bit is sent first |
| oe_req | input | 1 | Requested state of the driver output enable |
| drv_sclk | output | 1 | Divided shift clock to the driver chain |
| drv_sdat | output | 1 | Serial data to the first driver |
| drv_le | output | 1 | Latch pulse to all drivers |
| drv_oe | output | 1 | Output enable to all drivers |

## Verification
The embedded assertions check the following on every cycle:
- the exact high width of the shift clock;
- that data moves only while the clock is low;
- that the latch pulse never overlaps a clock-high phase;
- that the idle handshake state is quiet;
- the one-cycle tracking of output enable;
- that the bit counter never shifts past the frame end.

Some properties span many cycles or involve the chain contents. These are the low-phase minimum, the setup time, the distances from LE to the clock on both sides, the rising-edge count per frame, the bit order seen in the latches, and the fact that host inputs are ignored mid-frame. Only the bench shows these. Its behavioural chain model and its interval monitor run the bench's directed scenarios, including back-to-back frames and output-enable toggling during a transfer.

// File: rtl/serdrv_pkg.sv
package serdrv_pkg;

  // Driver timing minima in nanoseconds
  localparam int unsigned NS_SCLK_PHASE  = 62;
  localparam int unsigned NS_SCLK_PERIOD = 125;
  localparam int unsigned NS_LE_SPACE    = 50;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LE_WAIT,
    ST_LE_PULSE,
    ST_GAP
  } ld_state_e;

  // Cycles of a clock at hz needed to cover ns, rounded up, at least one
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned hz);
    longint unsigned c;
    c = (longint'(ns) * longint'(hz) + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return int'(c);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/serdrv_cnt.sv
module serdrv_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/serdrv_frame_sr.sv
module serdrv_frame_sr #(
  parameter int unsigned FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic [FRAME_W-1:0] din,
  output logic               head,
  output logic               done
);

  localparam int unsigned RW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [RW-1:0]      left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sr_q   <= din;
      left_q <= RW'(FRAME_W);
    end else if (shift) begin
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign head = sr_q[FRAME_W-1];
  assign done = (left_q == '0);

  // R3
  no_overshift_chk: assert property (@(posedge clk) disable iff (rst)
    shift |-> !done);

endmodule

// File: rtl/serdrv_loader.sv
module serdrv_loader
  import serdrv_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned N_DEV    = 2,
  parameter int unsigned DEV_BITS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_valid,
  output logic                      frame_ready,
  input  logic [N_DEV*DEV_BITS-1:0] frame_data,
  input  logic                      oe_req,
  output logic                      drv_sclk,
  output logic                      drv_sdat,
  output logic                      drv_le,
  output logic                      drv_oe
);

  localparam int unsigned FRAME_W = N_DEV * DEV_BITS;
  localparam int unsigned HI_CYC  = ns_to_cycles(NS_SCLK_PHASE, CLK_HZ);
  localparam int unsigned LO_CYC  = umax(HI_CYC, ns_to_cycles(NS_SCLK_PERIOD, CLK_HZ) - HI_CYC);
  localparam int unsigned LE_CYC  = ns_to_cycles(NS_LE_SPACE, CLK_HZ);
  localparam int unsigned MAX_CYC = umax(umax(HI_CYC, LO_CYC), LE_CYC);
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] HI_M1 = CW'(HI_CYC - 1);
  localparam logic [CW-1:0] LO_M1 = CW'(LO_CYC - 1);
  localparam logic [CW-1:0] LE_M1 = CW'(LE_CYC - 1);

  ld_state_e     st_q;
  logic          sclk_q, sdat_q, le_q, oe_q;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic          sr_load, sr_shift, sr_head, sr_done;

  serdrv_cnt #(.CW(CW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .val  (tmr_val),
    .zero (tmr_zero)
  );

  serdrv_frame_sr #(.FRAME_W(FRAME_W)) u_sr (
    .clk   (clk),
    .rst   (rst),
    .load  (sr_load),
    .shift (sr_shift),
    .din   (frame_data),
    .head  (sr_head),
    .done  (sr_done)
  );

  // Timer reloads and frame register strobes
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sr_load  = 1'b0;
    sr_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (frame_valid) begin
        sr_load  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = LO_M1;
      end
      ST_SHIFT: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (!sclk_q) begin
          sr_shift = 1'b1;
          tmr_val  = HI_M1;
        end else if (sr_done) begin
          tmr_val  = LE_M1;
        end else begin
          tmr_val  = LO_M1;
        end
      end
      ST_LE_WAIT, ST_LE_PULSE: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = LE_M1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      sdat_q <= 1'b0;
      le_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= oe_req;
      unique case (st_q)
        ST_IDLE: if (frame_valid) begin
          st_q   <= ST_SHIFT;
          sdat_q <= frame_data[FRAME_W-1];
        end
        ST_SHIFT: if (tmr_zero) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (sr_done) st_q   <= ST_LE_WAIT;
            else         sdat_q <= sr_head;
          end
        end
        ST_LE_WAIT: if (tmr_zero) begin
          le_q <= 1'b1;
          st_q <= ST_LE_PULSE;
        end
        ST_LE_PULSE: if (tmr_zero) begin
          le_q <= 1'b0;
          st_q <= ST_GAP;
        end
        ST_GAP: if (tmr_zero) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign frame_ready = (st_q == ST_IDLE);
  assign drv_sclk    = sclk_q;
  assign drv_sdat    = sdat_q;
  assign drv_le      = le_q;
  assign drv_oe      = oe_q;

  // Checker: length of the current high phase
  logic [CW-1:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (rst || !sclk_q) hi_run_q <= '0;
    else                hi_run_q <= hi_run_q + 1'b1;
  end

  // R1
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ready |-> (!drv_sclk && !drv_le));

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_ready) |=> !frame_ready);

  // R4
  hi_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_sclk) |-> (hi_run_q == CW'(HI_CYC)));

  // R5
  sdat_move_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(drv_sdat) |-> !drv_sclk);

  // R6
  le_clk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    drv_le |-> !drv_sclk);

  // R8
  oe_track_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (drv_oe == $past(oe_req)));

endmodule

// File: tb/tb_serdrv_loader.sv
`timescale 1ns/1ps
module tb_serdrv_loader;

  localparam int CLK_PERIOD = 20;
  localparam int CLK_HZ     = 50_000_000;
  localparam int N_DEV      = 2;
  localparam int W          = N_DEV * 32;

  function automatic longint cyc_up(input longint ns);
    longint c;
    c = (ns * CLK_HZ + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam longint T_HI = cyc_up(62);
  localparam longint T_LO = (cyc_up(125) - T_HI > T_HI) ? cyc_up(125) - T_HI : T_HI;
  localparam longint T_SU = cyc_up(25);
  localparam longint T_HD = cyc_up(10);
  localparam longint T_LE = cyc_up(50);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_valid = 1'b0;
  logic         frame_ready;
  logic [W-1:0] frame_data = '0;
  logic         oe_req = 1'b0;
  logic         drv_sclk, drv_sdat, drv_le, drv_oe;

  serdrv_loader #(.CLK_HZ(CLK_HZ), .N_DEV(N_DEV), .DEV_BITS(32)) dut (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_ready(frame_ready),
    .frame_data(frame_data), .oe_req(oe_req), .drv_sclk(drv_sclk),
    .drv_sdat(drv_sdat), .drv_le(drv_le), .drv_oe(drv_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural driver chain: one stage per rising edge, latch on pulse
  logic [W-1:0] chain = '0;
  logic [W-1:0] latched = '0;
  logic [W-1:0] hv;
  always @(posedge drv_sclk) chain <= {chain[W-2:0], drv_sdat};
  always @(posedge drv_le)   latched <= chain;
  assign hv = drv_oe ? latched : '0;

  // Interval monitor, sampled on the falling system-clock edge
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint lr = -1000, lf = -1000, lsd = -1000, ler = -1000, llef = -1000;
  bit     p_sclk = 0, p_sdat = 0, p_le = 0;
  int     rises = 0, le_rises = 0, le_falls = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (drv_sclk && !p_sclk) begin
        if (lf >= 0) chk(cyc - lf >= T_LO, "R4", "low phase", cyc - lf, T_LO);
        chk(cyc - lsd >= T_SU, "R5", "setup", cyc - lsd, T_SU);
        chk(!drv_le, "R6", "le during rise", drv_le, 0);
        if (llef >= 0) chk(cyc - llef >= T_LE, "R7", "le fall to rise", cyc - llef, T_LE);
        lr = cyc;
        rises++;
      end
      if (!drv_sclk && p_sclk) begin
        chk(cyc - lr == T_HI, "R4", "high phase", cyc - lr, T_HI);
        lf = cyc;
      end
      if (drv_sdat != p_sdat) begin
        chk(!drv_sclk, "R5", "data moved while high", drv_sclk, 0);
        if (lr >= 0) chk(cyc - lr >= T_HD, "R5", "hold", cyc - lr, T_HD);
        lsd = cyc;
      end
      if (drv_le && !p_le) begin
        chk(cyc - lr >= T_LE, "R6", "last rise to le", cyc - lr, T_LE);
        ler = cyc;
        le_rises++;
      end
      if (!drv_le && p_le) begin
        chk(cyc - ler >= T_LE, "R6", "le width", cyc - ler, T_LE);
        llef = cyc;
        le_falls++;
      end
    end
    p_sclk = drv_sclk;
    p_sdat = drv_sdat;
    p_le   = drv_le;
  end

  task automatic wait_le_done(input int lf0);
    while (le_falls == lf0) @(negedge clk);
  endtask

  task automatic t_reset;
    oe_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(drv_oe == 1'b0, "R9", "oe in reset", drv_oe, 0);
    chk(!drv_sclk && !drv_sdat && !drv_le, "R9", "pins in reset",
        {drv_sclk, drv_sdat, drv_le}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(frame_ready == 1'b1, "R9", "ready after reset", frame_ready, 1);
    chk(!drv_sclk && !drv_le, "R9", "quiet after reset", {drv_sclk, drv_le}, 0);
    chk(drv_oe == 1'b1, "R8", "oe follows request", drv_oe, 1);
  endtask

  task automatic t_send(input logic [W-1:0] f, input string name);
    int r0, lf0, lr0;
    @(negedge clk);
    frame_data  = f;
    frame_valid = 1'b1;
    while (!frame_ready) @(negedge clk);
    r0 = rises; lf0 = le_falls; lr0 = le_rises;
    @(negedge clk);
    frame_valid = 1'b0;
    frame_data  = ~f;
    chk(!frame_ready, "R1", {"ready after accept ", name}, frame_ready, 0);
    wait_le_done(lf0);
    chk(rises - r0 == W, "R3", {"edge count ", name}, rises - r0, W);
    chk(le_rises - lr0 == 1, "R6", {"pulse count ", name}, le_rises - lr0, 1);
    chk_vec("R3", {"latched ", name}, latched, f);
    while (!frame_ready) @(negedge clk);
  endtask

  // R2 and R7: valid held high with a new frame while busy
  task automatic t_busy;
    logic [W-1:0] a, b;
    int lf0, r0;
    a = 64'h0F0F_3C3C_A5A5_1248;
    b = 64'hF00D_0000_0001_8001;
    @(negedge clk);
    frame_data  = a;
    frame_valid = 1'b1;
    while (!frame_ready) @(negedge clk);
    lf0 = le_falls;
    @(negedge clk);
    frame_data = b;
    repeat (40) @(negedge clk);
    chk(!frame_ready, "R1", "ready mid frame", frame_ready, 0);
    frame_data = 64'hFFFF_FFFF_0000_0000;
    repeat (40) @(negedge clk);
    frame_data = b;
    wait_le_done(lf0);
    chk_vec("R2", "busy inputs ignored", latched, a);
    r0 = rises;
    lf0 = le_falls;
    wait_le_done(lf0);
    frame_valid = 1'b0;
    chk(rises - r0 == W, "R7", "back-to-back edge count", rises - r0, W);
    chk_vec("R7", "back-to-back latched", latched, b);
    while (!frame_ready) @(negedge clk);
  endtask

  // R8: output enable independent of loading
  task automatic t_oe;
    logic [W-1:0] f;
    int lf0;
    f = 64'h8000_0000_0000_0001;
    @(negedge clk);
    oe_req = 1'b0;
    frame_data = f;
    frame_valid = 1'b1;
    while (!frame_ready) @(negedge clk);
    lf0 = le_falls;
    @(negedge clk);
    frame_valid = 1'b0;
    chk(drv_oe == 1'b0, "R8", "oe low", drv_oe, 0);
    for (int k = 0; k < 6; k++) begin
      oe_req = k[0];
      @(negedge clk);
      chk(drv_oe == k[0], "R8", "oe toggles mid frame", drv_oe, k[0]);
    end
    oe_req = 1'b0;
    wait_le_done(lf0);
    chk_vec("R8", "outputs blanked", hv, '0);
    oe_req = 1'b1;
    @(negedge clk);
    chk_vec("R8", "outputs show latch", hv, f);
    while (!frame_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_send({W{1'b1}}, "ones");
    t_send('0, "zeros");
    t_send({(W/2){2'b10}}, "alternate");
    t_send(64'h0000_0000_0000_0001, "lsb");
    t_send(64'h8000_0000_0000_0000, "msb");
    t_send(64'h0123_4567_89AB_CDEF, "mixed");
    t_busy();
    t_oe();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule